// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Data Path

This block is the data side of a clocked synchronous serial port. One byte-wide shift register carries both directions at once. Outgoing bits leave from its bit 0 on `serOut`. Incoming bits, captured from `serIn`, enter at the top. An external clock unit supplies two single-cycle pulses: a sample pulse that latches the input bit, and a shift pulse that moves the register by one place.

A frame is one, two or four bytes long. Four transmit byte registers feed the shift register one byte after another. Four receive byte registers collect the finished bytes in order. A completed byte leaves the shift register on the same edge that the next transmit byte enters it, so back-to-back bytes and frames run with no idle bit. Bit order is chosen by reversing each byte as it passes between a byte register and the shift register, so the shift register always works from bit 0.

A CPU reaches the byte registers through a small bus with a 3-bit address. The receive-full flag tells the CPU that a whole frame is waiting. The overrun flag reports a frame that arrived before the previous one was collected.

Top module: `ssdp_top`

## Requirements
- R1: `frameLen` selects the frame size: 2'b00 gives one byte, which fills receive register 0. 2'b01 gives two bytes, in registers 0 and 1. 2'b10 and 2'b11 give four bytes, in registers 0 to 3. `rxFull` rises only after the last byte of the frame has been stored.
- R2: `serOut` is always shift-register bit 0. With `msbFirst`=0 a transmit byte leaves bit 0 first. With `msbFirst`=1 it leaves bit 7 first. `frameStart` loads transmit register 0. The 8th shift of a byte loads the next transmit register, and after the last byte of the frame it loads register 0 again.
- R3: A `sampleStb` pulse latches `serIn`, and each `shiftStb` pulse shifts the latched bit in. The first bit received lands in bit 0 of the receive register when `msbFirst`=0, and in bit 7 when `msbFirst`=1.
- R4: The bytes of one frame are stored in receive registers 0, 1, 2, 3 in arrival order. The first bit of the following byte can be shifted on the very next strobe.
- R5: `rxFull` is 0 after reset. It goes to 1 on the clock edge that stores the last byte of a frame. A bus read of the highest valid receive register clears it, and a read of a lower register leaves it set.
- R6: If a frame completes while `rxFull` is 1, `overrun` goes to 1 and no receive register changes during that frame. `frameStart` clears `overrun`.
- R7: Bus address bit 2 selects the register bank: 0 selects transmit registers and 1 selects receive registers, with bits 1:0 picking the index. Transmit registers can be written and read back. Writes to receive addresses have no effect. `busRdData` is 0 when `busRdEn` is 0.
- R8: `frameStart` clears the bit and byte counters and reloads the shift register, which discards a partial byte. It takes priority over a `shiftStb` in the same cycle.
- R9: After reset every byte register, the shift register, `serOut`, `rxFull` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameLen | input | 2 | Frame size select |
| msbFirst | input | 1 | 1 = most significant bit first |
| frameStart | input | 1 | Restart counters, load transmit register 0 |
| sampleStb | input | 1 | Latch `serIn` |
| shiftStb | input | 1 | Shift the register by one bit |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data |
| busWrEn | input | 1 | Bus write enable |
| busRdEn | input | 1 | Bus read enable |
| busAddr | input | 3 | Bit 2 selects the bank (0 transmit, 1 receive); bits 1:0 select the index |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Bus read data |
| rxFull | output | 1 | Complete frame waiting |
| overrun | output | 1 | A frame arrived while `rxFull` was set |

## Verification
The hardest case to reach is an overrun in the middle of a continuous four-byte stream. A whole second frame has to arrive with no `frameStart` and no read in between, while the first frame is still uncollected. The stimulus does this by shifting eight bytes back to back. It then reads the lower receive registers, confirms that `rxFull` stays set and that the old bytes survived, and finally reads the top register. Partial bytes cut short by `frameStart` are also exercised, including a `frameStart` that arrives together with a shift pulse.

// File: rtl/ssdp_pkg.sv
package ssdp_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 4;
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int ADDR_W    = IDX_W + 1;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic             loadShift;
    logic [IDX_W-1:0] loadIdx;
    logic             shiftEn;
    logic             storeRx;
    logic [IDX_W-1:0] storeIdx;
  } dpStrobe_t;

  function automatic logic [BYTE_W-1:0] flipByte(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/ssdp_ctrl.sv
module ssdp_ctrl
  import ssdp_pkg::*;
#(
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        frameLen,
  input  logic              frameStart,
  input  logic              shiftStb,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output dpStrobe_t         stb,
  output logic              rxFull,
  output logic              overrun
);
  localparam int CNT_W = $clog2(BYTE_W_P);

  logic [CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteCnt;
  logic [IDX_W-1:0] lastIdx;
  logic             byteDone;
  logic             frameDone;
  logic             rdLast;

  always_comb begin
    case (frameLen)
      2'b00:   lastIdx = '0;
      2'b01:   lastIdx = IDX_W'(1);
      default: lastIdx = IDX_W'(NUM_BYTES - 1);
    endcase
  end

  assign byteDone  = shiftStb && !frameStart && (bitCnt == CNT_W'(BYTE_W_P - 1));
  assign frameDone = byteDone && (byteCnt == lastIdx);
  assign rdLast    = busRdEn && (busAddr == {1'b1, lastIdx});

  always_comb begin
    stb.loadShift = frameStart || byteDone;
    if (frameStart || frameDone) stb.loadIdx = '0;
    else                         stb.loadIdx = byteCnt + IDX_W'(1);
    stb.shiftEn  = shiftStb && !frameStart;
    stb.storeRx  = byteDone && !rxFull;
    stb.storeIdx = byteCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (frameStart) begin
        bitCnt  <= '0;
        byteCnt <= '0;
      end else if (shiftStb) begin
        bitCnt <= byteDone ? '0 : bitCnt + CNT_W'(1);
        if (byteDone) byteCnt <= frameDone ? '0 : byteCnt + IDX_W'(1);
      end
      if (frameDone && !rxFull) rxFull <= 1'b1;
      else if (rdLast)          rxFull <= 1'b0;
      if (frameStart)                overrun <= 1'b0;
      else if (frameDone && rxFull)  overrun <= 1'b1;
    end
  end

  // R5: the flag only rises as a result of a shift pulse
  a_r5_full_from_shift: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(shiftStb));
  // R5: reading the top valid register empties the buffer
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && rdLast) |=> !rxFull);
  // R6: overrun needs an uncollected frame
  a_r6_overrun_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));
  // R8: restart clears position and overrun
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (bitCnt == '0 && byteCnt == '0 && !overrun));
endmodule

// File: rtl/ssdp_datapath.sv
module ssdp_datapath
  import ssdp_pkg::*;
#(
  parameter int BYTE_W_P    = BYTE_W,
  parameter int NUM_BYTES_P = NUM_BYTES
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msbFirst,
  input  logic                sampleStb,
  input  logic                serIn,
  input  dpStrobe_t           stb,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BYTE_W_P-1:0] busWrData,
  output logic [BYTE_W_P-1:0] busRdData,
  output logic                serOut
);
  logic [BYTE_W_P-1:0] txRegs [NUM_BYTES_P];
  logic [BYTE_W_P-1:0] rxRegs [NUM_BYTES_P];
  logic [BYTE_W_P-1:0] shiftReg;
  logic [BYTE_W_P-1:0] shiftNext;
  logic [BYTE_W_P-1:0] txPick;
  logic                sampledBit;
  logic [NUM_BYTES_P*BYTE_W_P-1:0] rxFlat;

  assign shiftNext = {sampledBit, shiftReg[BYTE_W_P-1:1]};
  assign txPick    = txRegs[stb.loadIdx];
  assign serOut    = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      sampledBit <= 1'b0;
    end else begin
      if (sampleStb) sampledBit <= serIn;
      if (stb.loadShift)    shiftReg <= msbFirst ? flipByte(txPick) : txPick;
      else if (stb.shiftEn) shiftReg <= shiftNext;
    end
  end

  for (genvar g = 0; g < NUM_BYTES_P; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txRegs[g] <= '0;
        rxRegs[g] <= '0;
      end else begin
        if (busWrEn && busAddr == {1'b0, IDX_W'(g)}) txRegs[g] <= busWrData;
        if (stb.storeRx && stb.storeIdx == IDX_W'(g))
          rxRegs[g] <= msbFirst ? flipByte(shiftNext) : shiftNext;
      end
    end
    assign rxFlat[g*BYTE_W_P +: BYTE_W_P] = rxRegs[g];
  end

  always_comb begin
    if (!busRdEn)                busRdData = '0;
    else if (busAddr[ADDR_W-1])  busRdData = rxRegs[busAddr[IDX_W-1:0]];
    else                         busRdData = txRegs[busAddr[IDX_W-1:0]];
  end

  // R2: a plain shift brings the next bit to the output
  a_r2_serout_shift: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftEn && !stb.loadShift) |=> serOut == $past(shiftReg[1]));
  // R3: the sample pulse captures the line
  a_r3_sample_capture: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> sampledBit == $past(serIn));
  // R6 R7: receive bytes change only on a store strobe
  a_r7_rx_only_on_store: assert property (@(posedge clk) disable iff (!rstN)
    !stb.storeRx |=> $stable(rxFlat));
endmodule

// File: rtl/ssdp_top.sv
module ssdp_top
  import ssdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        frameLen,
  input  logic              msbFirst,
  input  logic              frameStart,
  input  logic              sampleStb,
  input  logic              shiftStb,
  input  logic              serIn,
  output logic              serOut,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  output logic              rxFull,
  output logic              overrun
);
  dpStrobe_t stb;

  ssdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .frameStart(frameStart),
    .shiftStb(shiftStb), .busRdEn(busRdEn), .busAddr(busAddr),
    .stb(stb), .rxFull(rxFull), .overrun(overrun)
  );

  ssdp_datapath u_dp (
    .clk(clk), .rstN(rstN), .msbFirst(msbFirst), .sampleStb(sampleStb),
    .serIn(serIn), .stb(stb), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .serOut(serOut)
  );
endmodule

// File: tb/ssdp_top_tb.sv
`timescale 1ns/1ps
module ssdp_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] frameLen = 2'b00;
  logic       msbFirst = 1'b0;
  logic       frameStart = 1'b0;
  logic       sampleStb = 1'b0;
  logic       shiftStb = 1'b0;
  logic       serIn = 1'b0;
  logic       serOut;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       rxFull;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ssdp_top u_dut (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .msbFirst(msbFirst),
    .frameStart(frameStart), .sampleStb(sampleStb), .shiftStb(shiftStb),
    .serIn(serIn), .serOut(serOut), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .rxFull(rxFull), .overrun(overrun)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] mTx [4];
  bit txq [$];
  bit rxq [$];
  int bitc, bytec, lastI;
  bit mFull, mOv, mSample;

  function automatic void loadTx(logic [7:0] v, bit msb);
    txq.delete();
    for (int k = 0; k < 8; k++) txq.push_back(msb ? v[7-k] : v[k]);
  endfunction

  initial loadTx(8'h00, 1'b0);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mTx[i] = 8'h00;
      bitc = 0; bytec = 0; mFull = 0; mOv = 0; mSample = 0;
      rxq.delete();
      loadTx(8'h00, 1'b0);
    end else begin
      bit setF;
      setF = 0;
      lastI = (frameLen == 2'b00) ? 0 : (frameLen == 2'b01) ? 1 : 3;
      if (frameStart) begin
        bitc = 0; bytec = 0; mOv = 0;
        rxq.delete();
        loadTx(mTx[0], msbFirst);
      end else if (shiftStb) begin
        rxq.push_back(mSample);
        void'(txq.pop_front());
        bitc++;
        if (bitc == 8) begin
          if (bytec == lastI) begin
            if (mFull) mOv = 1; else setF = 1;
            bytec = 0;
          end else bytec++;
          bitc = 0;
          rxq.delete();
          loadTx(mTx[bytec], msbFirst);
        end
      end
      if (setF) mFull = 1;
      else if (busRdEn && busAddr == 3'(4 + lastI)) mFull = 0;
      if (sampleStb) mSample = serIn;
      if (busWrEn && !busAddr[2]) mTx[busAddr[1:0]] = busWrData;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every clock: compare registered outputs with the model
  always @(negedge clk) begin
    if (rstN && !finished && txq.size() > 0) begin
      check(serOut == txq[0], "R2 serOut", int'(serOut), int'(txq[0]));
      check(rxFull == mFull, "R5 rxFull", int'(rxFull), int'(mFull));
      check(overrun == mOv, "R6 overrun", int'(overrun), int'(mOv));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic busReadCheck(logic [2:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    busRdEn = 1; busAddr = a;
    #1;
    check(busRdData == exp, req, int'(busRdData), int'(exp));
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic startFrame(bit withShift);
    @(negedge clk);
    frameStart = 1; shiftStb = withShift;
    @(negedge clk);
    frameStart = 0; shiftStb = 0;
  endtask

  task automatic sendBits(logic [7:0] d, bit msb, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      shiftStb = 0; sampleStb = 1; serIn = msb ? d[7-k] : d[k];
      @(negedge clk);
      sampleStb = 0; shiftStb = 1;
    end
    @(negedge clk);
    shiftStb = 0;
  endtask

  task automatic sendByte(logic [7:0] d, bit msb);
    sendBits(d, msb, 8);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    check(serOut == 0, "R9 serOut", int'(serOut), 0);
    check(rxFull == 0, "R9 rxFull", int'(rxFull), 0);
    check(overrun == 0, "R9 overrun", int'(overrun), 0);
    for (int i = 0; i < 4; i++) busReadCheck(3'(4 + i), 8'h00, "R9 rx reg");
    busReadCheck(3'd0, 8'h00, "R9 tx reg");

    // R7 register map, receive side read-only
    busWrite(3'd0, 8'hA5);
    busWrite(3'd1, 8'h3C);
    busWrite(3'd2, 8'h0F);
    busWrite(3'd3, 8'h81);
    busWrite(3'd5, 8'hFF);
    busReadCheck(3'd5, 8'h00, "R7 write to rx ignored");
    busReadCheck(3'd0, 8'hA5, "R7 tx readback");
    busReadCheck(3'd3, 8'h81, "R7 tx readback");
    #1 check(busRdData == 0, "R7 idle read data", int'(busRdData), 0);

    // R3 one byte, LSB first
    frameLen = 2'b00; msbFirst = 0;
    startFrame(0);
    sendByte(8'h6B, 0);
    check(rxFull == 1, "R5 set after byte", int'(rxFull), 1);
    busReadCheck(3'd4, 8'h6B, "R3 lsb receive");
    check(rxFull == 0, "R5 cleared by read", int'(rxFull), 1'b0);

    // R3 one byte, MSB first
    msbFirst = 1;
    startFrame(0);
    sendByte(8'h9E, 1);
    busReadCheck(3'd4, 8'h9E, "R3 msb receive");

    // R1 R4 two-byte frame
    frameLen = 2'b01; msbFirst = 0;
    startFrame(0);
    sendByte(8'h12, 0);
    check(rxFull == 0, "R1 not full mid frame", int'(rxFull), 0);
    sendByte(8'h34, 0);
    check(rxFull == 1, "R1 full after 2 bytes", int'(rxFull), 1);
    busReadCheck(3'd4, 8'h12, "R4 byte 0");
    check(rxFull == 1, "R5 low read keeps flag", int'(rxFull), 1);
    busReadCheck(3'd5, 8'h34, "R4 byte 1");
    check(rxFull == 0, "R5 top read clears", int'(rxFull), 0);

    // R6 four-byte frames back to back, second overruns
    frameLen = 2'b10;
    startFrame(0);
    sendByte(8'h11, 0); sendByte(8'h22, 0); sendByte(8'h33, 0); sendByte(8'h44, 0);
    check(rxFull == 1, "R1 full after 4 bytes", int'(rxFull), 1);
    sendByte(8'h55, 0); sendByte(8'h66, 0); sendByte(8'h77, 0); sendByte(8'h88, 0);
    check(overrun == 1, "R6 overrun set", int'(overrun), 1);
    busReadCheck(3'd4, 8'h11, "R6 kept byte 0");
    busReadCheck(3'd5, 8'h22, "R6 kept byte 1");
    busReadCheck(3'd6, 8'h33, "R6 kept byte 2");
    check(rxFull == 1, "R5 still full", int'(rxFull), 1);
    busReadCheck(3'd7, 8'h44, "R6 kept byte 3");
    check(rxFull == 0, "R5 cleared by reg 3", int'(rxFull), 0);
    startFrame(0);
    check(overrun == 0, "R6 cleared by start", int'(overrun), 0);

    // R8 partial byte discarded by restart
    frameLen = 2'b00;
    startFrame(0);
    sendBits(8'hFF, 0, 3);
    startFrame(0);
    sendByte(8'hC4, 0);
    busReadCheck(3'd4, 8'hC4, "R8 restart discards partial");

    // R8 start wins over simultaneous shift
    startFrame(1);
    sendByte(8'h5A, 0);
    busReadCheck(3'd4, 8'h5A, "R8 start priority");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule